// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block is a clocked sequencer that runs a 64K-word by 16-bit asynchronous static RAM from a synchronous host. The host offers one request at a time through a valid/ready handshake. A request carries a direction bit, a word address, write data and one enable per byte lane. The controller then drives the memory pins through a fixed sequence of registered states. When the access has finished, it raises a one-cycle completion pulse. For a read, the word taken from the bus is presented at the same time as that pulse.

The memory has two selects of opposite polarity, one active-low and one active-high. It has active-low write-enable and output-enable strobes, two active-low byte strobes, and a shared three-state data bus. The wait for the access time is a count of clock cycles derived from two parameters: the access time and the clock period, both in nanoseconds. The count is the ratio rounded up, with a floor of two cycles. Whenever no request is in flight, the controller leaves the memory in its low-power standby state. It does this by holding the active-low select high, the active-high select low, and both byte strobes high.

Top module: `sram_ctrl`

## Requirements
- R1: While no request is in progress, including right after reset, the controller holds `mem_cs1_n`=1, `mem_cs2`=0, `mem_ub_n`=`mem_lb_n`=1, `mem_we_n`=`mem_oe_n`=1 and does not drive `mem_dq`.
- R2: `req_ready` is 1 only in the idle state. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 from that edge until the request completes.
- R3: The access wait is ceil(`ACCESS_NS`/`CLK_NS`) cycles, at least 2. A read holds `mem_cs1_n`=0, `mem_cs2`=1, `mem_oe_n`=0 and `mem_we_n`=1 for exactly that many cycles, starting with the cycle after the accepting edge.
- R4: Read data is captured at the edge that ends the read strobe and appears on `rsp_rdata` during the following cycle. In that same cycle `rsp_done` is 1, and it is 1 for that cycle only.
- R5: `req_be[0]` enables bits 7:0 through `mem_lb_n`=0, and `req_be[1]` enables bits 15:8 through `mem_ub_n`=0. A lane whose enable is 0 keeps its strobe at 1, and its memory byte is left unchanged by a write.
- R6: A write keeps `mem_oe_n`=1 throughout. It spends one setup cycle with the selects and address asserted before `mem_we_n` falls, two cycles after the accepting edge, and then holds `mem_we_n`=0 for the access wait.
- R7: The data driver turns on only in the cycle after `mem_we_n` has gone low. It stays on for one hold cycle after `mem_we_n` rises, and is off during reads and idle, so the written word reaches the memory intact.
- R8: `mem_addr` and the byte strobes stay constant for as long as the selects are asserted within a request.
- R9: A write that directly follows a read gets one extra cycle with the selects and all drivers released, so `mem_we_n` falls three cycles after the accepting edge. Back-to-back writes keep the two-cycle delay.
- R10: Every write also ends with a single-cycle `rsp_done`, one cycle after the hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = low byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read word |
| mem_addr | output | 16 | Memory address pins |
| mem_cs1_n | output | 1 | Active-low select |
| mem_cs2 | output | 1 | Active-high select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_ub_n | output | 1 | Active-low upper byte strobe |
| mem_lb_n | output | 1 | Active-low lower byte strobe |
| mem_dq | inout | 16 | Three-state data bus |

## Verification
The bench builds the controller with `ACCESS_NS`=45 and `CLK_NS`=10. Because 4.5 cycles must round up to 5, a truncating division would show up directly in the measured strobe widths. A five-cycle wait also leaves room to see the driver turn on one cycle after the write strobe falls while the strobe is still low. Full 16-bit addresses are used, including 0x0000 and 0xFFFF. The requests run in read-then-write, write-then-write and single-lane orders, which exercise the turnaround cycle and the byte-lane masking against a behavioural memory on the shared bus.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TURN,
    S_WSETUP,
    S_WPULSE,
    S_WHOLD,
    S_READ
  } ctrl_state_e;

  // Cycles needed to cover an access time, rounded up, never below two
  // so that a write has a driven cycle before its strobe ends.
  function automatic int unsigned wait_cycles(input int unsigned acc_ns,
                                              input int unsigned clk_ns);
    int unsigned c;
    c = (acc_ns + clk_ns - 1) / clk_ns;
    return (c < 2) ? 2 : c;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int unsigned WAIT_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LANES-1:0]  in_be,
  output logic [ADDR_W-1:0] held_addr,
  output logic [DATA_W-1:0] held_data,
  output logic [LANES-1:0]  held_be
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_addr <= '0;
      held_data <= '0;
      held_be   <= '0;
    end else if (capture) begin
      held_addr <= in_addr;
      held_data <= in_data;
      held_be   <= in_be;
    end
  end
endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drive_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sample,
  output logic [DATA_W-1:0] rdata,
  inout  wire  [DATA_W-1:0] dq
);
  localparam int unsigned LANE_W = DATA_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dq[g*LANE_W +: LANE_W] = drive_en ? wdata[g*LANE_W +: LANE_W]
                                             : {LANE_W{1'bz}};
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (sample)
      rdata <= dq;
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ACCESS_NS = 55,
  parameter int unsigned CLK_NS    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  inout  wire  [DATA_W-1:0] mem_dq
);
  localparam int unsigned WAIT_CYC = wait_cycles(ACCESS_NS, CLK_NS);
  localparam int unsigned LANES    = DATA_W / 8;

  ctrl_state_e       state;
  logic              cs1_n_q, cs2_q, we_n_q, oe_n_q;
  logic [LANES-1:0]  lane_n_q;
  logic              drv_q, ready_q, done_q, last_rd_q;
  logic              accept, tm_load, tm_zero, rd_sample;
  logic [DATA_W-1:0] held_data;
  logic [LANES-1:0]  held_be;

  assign accept    = (state == S_IDLE) && req_valid;
  assign tm_load   = (accept && !req_write) || (state == S_WSETUP);
  assign rd_sample = (state == S_READ) && tm_zero;

  sram_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk(clk), .rst(rst), .load(tm_load), .expired(tm_zero)
  );

  sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_hold (
    .clk(clk), .rst(rst), .capture(accept),
    .in_addr(req_addr), .in_data(req_wdata), .in_be(req_be),
    .held_addr(mem_addr), .held_data(held_data), .held_be(held_be)
  );

  sram_dq_port #(.DATA_W(DATA_W), .LANES(LANES)) u_dq (
    .clk(clk), .rst(rst), .drive_en(drv_q), .wdata(held_data),
    .sample(rd_sample), .rdata(rsp_rdata), .dq(mem_dq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cs1_n_q   <= 1'b1;
      cs2_q     <= 1'b0;
      we_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      lane_n_q  <= '1;
      drv_q     <= 1'b0;
      ready_q   <= 1'b1;
      done_q    <= 1'b0;
      last_rd_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            ready_q <= 1'b0;
            if (!req_write) begin
              cs1_n_q  <= 1'b0;
              cs2_q    <= 1'b1;
              lane_n_q <= ~req_be;
              oe_n_q   <= 1'b0;
              state    <= S_READ;
            end else if (last_rd_q) begin
              state    <= S_TURN;
            end else begin
              cs1_n_q  <= 1'b0;
              cs2_q    <= 1'b1;
              lane_n_q <= ~req_be;
              state    <= S_WSETUP;
            end
          end
        end
        S_TURN: begin
          cs1_n_q   <= 1'b0;
          cs2_q     <= 1'b1;
          lane_n_q  <= ~held_be;
          last_rd_q <= 1'b0;
          state     <= S_WSETUP;
        end
        S_WSETUP: begin
          we_n_q <= 1'b0;
          state  <= S_WPULSE;
        end
        S_WPULSE: begin
          drv_q <= 1'b1;
          if (tm_zero) begin
            we_n_q <= 1'b1;
            state  <= S_WHOLD;
          end
        end
        S_WHOLD: begin
          drv_q     <= 1'b0;
          cs1_n_q   <= 1'b1;
          cs2_q     <= 1'b0;
          lane_n_q  <= '1;
          done_q    <= 1'b1;
          ready_q   <= 1'b1;
          last_rd_q <= 1'b0;
          state     <= S_IDLE;
        end
        S_READ: begin
          if (tm_zero) begin
            cs1_n_q   <= 1'b1;
            cs2_q     <= 1'b0;
            oe_n_q    <= 1'b1;
            lane_n_q  <= '1;
            done_q    <= 1'b1;
            ready_q   <= 1'b1;
            last_rd_q <= 1'b1;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = ready_q;
  assign rsp_done  = done_q;
  assign mem_cs1_n = cs1_n_q;
  assign mem_cs2   = cs2_q;
  assign mem_we_n  = we_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_lb_n  = lane_n_q[0];
  assign mem_ub_n  = lane_n_q[LANES-1];
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WAIT_CYC = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs1_n,
  input logic              mem_cs2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic              drv_en
);
  localparam int unsigned CW = $clog2(WAIT_CYC + 2);
  logic [CW-1:0] oe_run;

  always_ff @(posedge clk) begin
    if (rst || mem_oe_n) oe_run <= '0;
    else                 oe_run <= oe_run + 1'b1;
  end

  // R1 / R2: an idle controller leaves the memory in standby
  p_idle_standby_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs1_n && !mem_cs2 && mem_ub_n && mem_lb_n
                   && mem_we_n && mem_oe_n && !drv_en));

  // R3: read strobe never longer than the wait count
  p_read_len_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (oe_run < CW'(WAIT_CYC)));

  // R4: completion pulse is one cycle wide
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R6: output enable stays high while writing
  p_no_oe_in_write_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  // R7: driver starts only after a low write strobe, never during a read
  p_drive_after_we_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_en) |-> (!mem_we_n && $past(!mem_we_n)));

  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !drv_en);

  // R8: address and lanes hold across the write strobe and its hold cycle
  p_addr_stable_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!mem_we_n) |-> ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n)));
endmodule

bind sram_ctrl sram_ctrl_checker #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_done(rsp_done),
  .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n),
  .mem_lb_n(mem_lb_n), .drv_en(drv_q)
);

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
  localparam int EXP_WAIT = 5;  // ceil(45 ns / 10 ns)

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata, mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n;
  wire  [15:0] mem_dq;

  always #5 clk = ~clk;

  sram_ctrl #(.ADDR_W(16), .DATA_W(16), .ACCESS_NS(45), .CLK_NS(10)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n),
    .mem_lb_n(mem_lb_n), .mem_dq(mem_dq)
  );

  // behavioural memory on the shared bus
  logic [15:0] mem [int];
  logic [15:0] mem_word;
  logic        mem_rd;
  always_comb begin
    mem_word = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
    mem_rd   = !mem_cs1_n && mem_cs2 && mem_we_n && !mem_oe_n;
  end
  assign mem_dq[7:0]  = (mem_rd && !mem_lb_n) ? mem_word[7:0]  : 8'hzz;
  assign mem_dq[15:8] = (mem_rd && !mem_ub_n) ? mem_word[15:8] : 8'hzz;

  always @(posedge mem_we_n) begin
    if (!mem_cs1_n && mem_cs2) begin
      logic [15:0] w;
      w = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
      if (!mem_lb_n) w[7:0]  = mem_dq[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq[15:8];
      mem[int'(mem_addr)] = w;
    end
  end

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { bit rd; logic [15:0] mask; logic [15:0] data; string rq; } exp_t;
  exp_t        exp_q[$];
  logic [15:0] shadow [int];
  logic        prev_done = 1'b0;

  always @(negedge clk) begin
    if (!rst && rsp_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "done with nothing pending", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.rd)
          check((rsp_rdata & e.mask) == (e.data & e.mask), e.rq, "read data",
                {16'h0, rsp_rdata & e.mask}, {16'h0, e.data & e.mask});
        else
          check(1'b1, "R10", "write done", 32'd1, 32'd1);
        check(!prev_done, "R4", "done width", {31'b0, prev_done}, 32'd0);
      end
    end
    prev_done = rsp_done;
  end

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // issues a request; returns at the negedge right after the accepting edge
  task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] be, input string rq);
    exp_t e;
    logic [15:0] m, cur;
    m   = {{8{be[1]}}, {8{be[0]}}};
    cur = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    e.rd = !wr; e.mask = m; e.data = cur; e.rq = rq;
    if (wr) shadow[int'(a)] = (cur & ~m) | (d & m);
    exp_q.push_back(e);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~d;
    check(!req_ready, "R2", "ready drops after accept", {31'b0, req_ready}, 32'd0);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] be, input int exp_delay, input string drq);
    int delay = 1, low = 0;
    bit oe_bad = 0, addr_bad = 0, lane_bad = 0;
    issue(1'b1, a, d, be, "R7");
    while (mem_we_n) begin
      if (!mem_oe_n) oe_bad = 1;
      @(negedge clk);
      delay++;
    end
    check(delay == exp_delay, drq, "we_n fall delay", delay, exp_delay);
    while (!mem_we_n) begin
      low++;
      if (!mem_oe_n) oe_bad = 1;
      if (mem_addr != a) addr_bad = 1;
      if ({mem_ub_n, mem_lb_n} != ~be) lane_bad = 1;
      @(negedge clk);
    end
    check(low == EXP_WAIT, "R6", "we_n low cycles", low, EXP_WAIT);
    check(!oe_bad, "R6", "oe_n high during write", {31'b0, oe_bad}, 32'd0);
    check(!addr_bad, "R8", "address held", {31'b0, addr_bad}, 32'd0);
    check(!lane_bad, "R5", "lane strobes on write", {31'b0, lane_bad}, 32'd0);
    wait_idle();
  endtask

  task automatic do_read(input logic [15:0] a, input logic [1:0] be, input string rq);
    int low = 0;
    bit sel_bad = 0, lane_bad = 0;
    issue(1'b0, a, 16'h0, be, rq);
    while (!mem_oe_n) begin
      low++;
      if (mem_cs1_n || !mem_cs2 || !mem_we_n) sel_bad = 1;
      if ({mem_ub_n, mem_lb_n} != ~be) lane_bad = 1;
      @(negedge clk);
    end
    check(low == EXP_WAIT, "R3", "oe_n low cycles", low, EXP_WAIT);
    check(!sel_bad, "R3", "selects during read", {31'b0, sel_bad}, 32'd0);
    check(!lane_bad, "R5", "lane strobes on read", {31'b0, lane_bad}, 32'd0);
    check(rsp_done, "R4", "done right after strobe", {31'b0, rsp_done}, 32'd1);
    wait_idle();
  endtask

  task automatic check_standby(input string what);
    check(mem_cs1_n && !mem_cs2 && mem_ub_n && mem_lb_n && mem_we_n && mem_oe_n && req_ready,
          "R1", what,
          {25'b0, req_ready, mem_cs1_n, mem_cs2, mem_ub_n, mem_lb_n, mem_we_n, mem_oe_n},
          32'b1101111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_standby("standby after reset");

    do_write(16'h0010, 16'hA5C3, 2'b11, 2, "R6");
    do_read (16'h0010, 2'b11, "R4");
    do_write(16'h0010, 16'h7E00, 2'b10, 3, "R9");   // read then write
    do_read (16'h0010, 2'b11, "R5");                // expect 7EC3
    do_write(16'hFFFF, 16'h1234, 2'b11, 3, "R9");
    do_write(16'h0000, 16'hBEEF, 2'b01, 2, "R9");   // write then write
    do_write(16'h8001, 16'h55AA, 2'b11, 2, "R6");
    do_read (16'h0000, 2'b01, "R5");
    do_read (16'hFFFF, 2'b11, "R7");
    do_read (16'h8001, 2'b10, "R5");
    do_write(16'h8001, 16'h0F0F, 2'b00, 3, "R9");   // no lanes: memory unchanged
    do_read (16'h8001, 2'b11, "R5");
    check_standby("standby after traffic");
    repeat (3) @(negedge clk);
    check_standby("standby held while idle");
    check(exp_q.size() == 0, "R10", "all requests completed", exp_q.size(), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule